// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. It moves one item at a time between a byte-addressed buffer RAM and a single peripheral data register. The channel holds a static setup: item size (byte or 16-bit word), direction, an addressing mode for the RAM side, and an option to write zero to the peripheral on receives. It also holds a RAM base address, the peripheral register address and the number of items per block. Each one-cycle request from the peripheral starts a read phase and then a write phase. The channel works out the RAM address for that item, counts finished items, and reports when the block is complete.

The channel takes the data it reads in the read phase and writes it in the next cycle. RAM and peripheral reads return data in the same cycle as the strobe. In byte mode the RAM returns the addressed byte on the low lane. Collision inputs from the bus fabric mark a write of this channel that met another write to the same location. The channel keeps a sticky flag for each side. Pulling the enable low parks the channel, reloads the base address, clears the item count and clears both flags.

Top module: `dma_channel`

## Requirements
- R1: With `size_byte`=0, data moves as 16-bit words and bit 0 of `ram_addr` is always driven 0, whatever the address register holds.
- R2: With `size_byte`=1, any RAM address (odd or even) is used as is, and only bits [7:0] of the data read are passed on, with bits [15:8] written as zero.
- R3: With `addr_mode`=2'b00, the RAM address register advances after each finished item by 2 for words and by 1 for bytes.
- R4: With `addr_mode`=2'b01 or the reserved 2'b11, the RAM address stays at the base address for every item.
- R5: With `addr_mode`=2'b10, the RAM address is `ram_base` bitwise-ORed with the `req_offset` sampled alongside that item's request, and bit 0 is cleared in word mode.
- R6: The peripheral side always uses `per_addr_cfg` on `per_addr`, with no increment.
- R7: With `dir_to_per`=0, the read phase strobes `per_rd` and the write phase strobes `ram_wr`. With `dir_to_per`=1, the read phase strobes `ram_rd` and the write phase strobes `per_wr`, carrying the data read.
- R8: With `null_wr`=1 and `dir_to_per`=0, the write phase also strobes `per_wr` with `per_wdata`=0. With `dir_to_per`=1, `null_wr` has no effect.
- R9: A request sampled high in an idle cycle gives a read phase in the next cycle and a write phase in the cycle after. One request sampled during a transfer is held and served right after that write phase, using its own offset.
- R10: After the `xfer_count`-th item (counted in items, not bytes, with `xfer_count` at least 1), `done` is high for exactly the cycle after that write phase. The address register then reloads `ram_base` and the item count restarts from zero.
- R11: `ram_conflict` during a write phase with `ram_wr` high sets the sticky flag `col_ram`. `per_conflict` during a write phase with `per_wr` high sets the sticky flag `col_per`. Both flags clear only while `enable` is low.
- R12: After reset, and while `enable` is low, no strobe is driven, requests are ignored, and `done`, `col_ram` and `col_per` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low parks and reinitialises the channel |
| size_byte | input | 1 | 1 = byte items, 0 = word items |
| dir_to_per | input | 1 | 1 = RAM to peripheral, 0 = peripheral to RAM |
| addr_mode | input | 2 | 00 post-increment, 01 fixed, 10 peripheral-offset, 11 fixed |
| null_wr | input | 1 | Write zero to the peripheral on each receive |
| ram_base | input | AW | RAM base address |
| per_addr_cfg | input | PW | Peripheral register address |
| xfer_count | input | CW | Items per block |
| req | input | 1 | One-cycle transfer request |
| req_offset | input | AW | Peripheral-supplied RAM offset, sampled with `req` |
| ram_addr | output | AW | RAM byte address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data (addressed byte on [7:0] in byte mode) |
| per_addr | output | PW | Peripheral register address |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |
| ram_conflict | input | 1 | Another master wrote the same RAM location this cycle |
| per_conflict | input | 1 | Another master wrote the same peripheral register this cycle |
| done | output | 1 | One-cycle block-complete pulse |
| col_ram | output | 1 | Sticky RAM write collision flag |
| col_per | output | 1 | Sticky peripheral write collision flag |

## Verification
Random setups vary size, direction, all four address modes, the null-write option and block lengths from one to four. Each block runs one item past its length, which shows whether the address reload and restarted count after `done` are right in every mode. Odd base addresses in both sizes separate the word-alignment clearing from the byte path. Peripheral-offset runs with random offsets check that the offset is ORed with the base and that the stepped register is not used. A request held across the read phase checks that the pending request keeps its own offset. Conflict pulses applied one side at a time check that each flag is set by its own write strobe and nothing else.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dma_state_t;

  localparam logic [1:0] AM_INC  = 2'b00;
  localparam logic [1:0] AM_FIX  = 2'b01;
  localparam logic [1:0] AM_PIND = 2'b10;

endpackage

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          req,
  input  logic [CW-1:0] xfer_count,
  output dma_state_t    state_o,
  output logic          start_o,
  output logic          use_pend_o,
  output logic          pend_ld_o,
  output logic          adv_o,
  output logic          last_o,
  output logic          done_o
);

  dma_state_t    st_q, st_n;
  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          last;

  assign last = ((cnt_q + CW'(1)) == xfer_count);

  always_comb begin
    st_n       = st_q;
    pend_n     = pend_q;
    cnt_n      = cnt_q;
    done_n     = 1'b0;
    start_o    = 1'b0;
    use_pend_o = 1'b0;
    pend_ld_o  = 1'b0;
    if (!enable) begin
      st_n   = ST_IDLE;
      pend_n = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req) begin
            st_n    = ST_RD;
            start_o = 1'b1;
          end
        end
        ST_RD: begin
          st_n = ST_WR;
          if (req) begin
            pend_n    = 1'b1;
            pend_ld_o = 1'b1;
          end
        end
        ST_WR: begin
          cnt_n  = last ? '0 : cnt_q + CW'(1);
          done_n = last;
          if (pend_q || req) begin
            st_n       = ST_RD;
            start_o    = 1'b1;
            use_pend_o = pend_q;
          end else begin
            st_n = ST_IDLE;
          end
          pend_n    = pend_q & req;
          pend_ld_o = pend_q & req;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign state_o = st_q;
  assign adv_o   = enable && (st_q == ST_WR);
  assign last_o  = last;
  assign done_o  = done_q;

  // R9
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR) |-> $past(st_q == ST_RD));

  // R9
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && req && st_q == ST_RD) |=> pend_q);

  // R10
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == ST_WR));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && xfer_count != '0 && $stable(xfer_count)) |-> (cnt_q < xfer_count));

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          size_byte,
  input  logic [1:0]    addr_mode,
  input  logic [AW-1:0] ram_base,
  input  logic [AW-1:0] req_offset,
  input  logic          start,
  input  logic          use_pend,
  input  logic          pend_ld,
  input  logic          adv,
  input  logic          last,
  output logic [AW-1:0] eff_addr
);

  logic [AW-1:0] addr_q, addr_n;
  logic [AW-1:0] off_q, off_n;
  logic [AW-1:0] poff_q, poff_n;
  logic [AW-1:0] step;
  logic [AW-1:0] base_sel;

  assign step = size_byte ? AW'(1) : AW'(2);

  always_comb begin
    addr_n = addr_q;
    off_n  = off_q;
    poff_n = poff_q;
    if (!enable) begin
      addr_n = ram_base;
    end else if (adv) begin
      if (last)                    addr_n = ram_base;
      else if (addr_mode == AM_INC) addr_n = addr_q + step;
    end
    if (start)   off_n  = use_pend ? poff_q : req_offset;
    if (pend_ld) poff_n = req_offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      off_q  <= '0;
      poff_q <= '0;
    end else begin
      addr_q <= addr_n;
      off_q  <= off_n;
      poff_q <= poff_n;
    end
  end

  assign base_sel = (addr_mode == AM_PIND) ? (ram_base | off_q) : addr_q;
  assign eff_addr = size_byte ? base_sel : {base_sel[AW-1:1], 1'b0};

  // R3
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && adv && !last && addr_mode == AM_INC) |=> (addr_q == $past(addr_q) + $past(step)));

  // R4
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && adv && !last && addr_mode != AM_INC) |=> $stable(addr_q));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && adv && last) |=> (addr_q == $past(ram_base)));

endmodule

// File: rtl/dma_chan_data.sv
module dma_chan_data
  import dma_chan_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  dma_state_t    state,
  input  logic          size_byte,
  input  logic          dir_to_per,
  input  logic          null_wr,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] per_rdata,
  input  logic          ram_conflict,
  input  logic          per_conflict,
  output logic          ram_rd,
  output logic          ram_wr,
  output logic          per_rd,
  output logic          per_wr,
  output logic [DW-1:0] ram_wdata,
  output logic [DW-1:0] per_wdata,
  output logic          col_ram,
  output logic          col_per
);

  logic [DW-1:0] data_q, data_n;
  logic [DW-1:0] src;
  logic          cram_q, cram_n;
  logic          cper_q, cper_n;
  logic          in_rd, in_wr;

  assign in_rd = enable && (state == ST_RD);
  assign in_wr = enable && (state == ST_WR);

  assign ram_rd = in_rd &  dir_to_per;
  assign per_rd = in_rd & ~dir_to_per;
  assign ram_wr = in_wr & ~dir_to_per;
  assign per_wr = in_wr & (dir_to_per | null_wr);

  assign src = dir_to_per ? ram_rdata : per_rdata;

  always_comb begin
    data_n = data_q;
    if (in_rd) data_n = size_byte ? {{(DW-8){1'b0}}, src[7:0]} : src;
    cram_n = enable && (cram_q || (ram_wr && ram_conflict));
    cper_n = enable && (cper_q || (per_wr && per_conflict));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cram_q <= 1'b0;
      cper_q <= 1'b0;
    end else begin
      data_q <= data_n;
      cram_q <= cram_n;
      cper_q <= cper_n;
    end
  end

  assign ram_wdata = data_q;
  assign per_wdata = dir_to_per ? data_q : '0;
  assign col_ram   = cram_q;
  assign col_per   = cper_q;

  // R11
  col_ram_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cram_q) |=> cram_q);

  // R11
  col_per_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cper_q) |=> cper_q);

  // R7
  one_ram_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd, ram_wr}));

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_chan_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 11,
  parameter int CW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          size_byte,
  input  logic          dir_to_per,
  input  logic [1:0]    addr_mode,
  input  logic          null_wr,
  input  logic [AW-1:0] ram_base,
  input  logic [PW-1:0] per_addr_cfg,
  input  logic [CW-1:0] xfer_count,
  input  logic          req,
  input  logic [AW-1:0] req_offset,
  output logic [AW-1:0] ram_addr,
  output logic          ram_rd,
  output logic          ram_wr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [PW-1:0] per_addr,
  output logic          per_rd,
  output logic          per_wr,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata,
  input  logic          ram_conflict,
  input  logic          per_conflict,
  output logic          done,
  output logic          col_ram,
  output logic          col_per
);

  dma_state_t state;
  logic       start, use_pend, pend_ld, adv, last;

  dma_chan_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .req        (req),
    .xfer_count (xfer_count),
    .state_o    (state),
    .start_o    (start),
    .use_pend_o (use_pend),
    .pend_ld_o  (pend_ld),
    .adv_o      (adv),
    .last_o     (last),
    .done_o     (done)
  );

  dma_chan_addr #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .size_byte  (size_byte),
    .addr_mode  (addr_mode),
    .ram_base   (ram_base),
    .req_offset (req_offset),
    .start      (start),
    .use_pend   (use_pend),
    .pend_ld    (pend_ld),
    .adv        (adv),
    .last       (last),
    .eff_addr   (ram_addr)
  );

  dma_chan_data #(.DW(DW)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .state        (state),
    .size_byte    (size_byte),
    .dir_to_per   (dir_to_per),
    .null_wr      (null_wr),
    .ram_rdata    (ram_rdata),
    .per_rdata    (per_rdata),
    .ram_conflict (ram_conflict),
    .per_conflict (per_conflict),
    .ram_rd       (ram_rd),
    .ram_wr       (ram_wr),
    .per_rd       (per_rd),
    .per_wr       (per_wr),
    .ram_wdata    (ram_wdata),
    .per_wdata    (per_wdata),
    .col_ram      (col_ram),
    .col_per      (col_per)
  );

  assign per_addr = per_addr_cfg;

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(ram_rd || ram_wr || per_rd || per_wr));

endmodule

// File: tb/dma_channel_tb.sv
`timescale 1ns/1ps
module dma_channel_tb;

  localparam int AW = 11;
  localparam int PW = 11;
  localparam int CW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable, size_byte, dir_to_per, null_wr, req;
  logic [1:0]    addr_mode;
  logic [AW-1:0] ram_base, req_offset, ram_addr;
  logic [PW-1:0] per_addr_cfg, per_addr;
  logic [CW-1:0] xfer_count;
  logic          ram_rd, ram_wr, per_rd, per_wr, done, col_ram, col_per;
  logic [DW-1:0] ram_wdata, ram_rdata, per_wdata, per_rdata;
  logic          ram_conflict, per_conflict;

  int n_run  = 0;
  int n_fail = 0;

  logic [AW-1:0] m_addr;
  int            m_cnt;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] ram_fn(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
  endfunction

  assign ram_rdata = ram_fn(ram_addr);

  dma_channel #(.AW(AW), .PW(PW), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .size_byte(size_byte),
    .dir_to_per(dir_to_per), .addr_mode(addr_mode), .null_wr(null_wr),
    .ram_base(ram_base), .per_addr_cfg(per_addr_cfg), .xfer_count(xfer_count),
    .req(req), .req_offset(req_offset), .ram_addr(ram_addr), .ram_rd(ram_rd),
    .ram_wr(ram_wr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .ram_conflict(ram_conflict), .per_conflict(per_conflict),
    .done(done), .col_ram(col_ram), .col_per(col_per)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_eff(input logic [AW-1:0] off);
    logic [AW-1:0] b;
    b = (addr_mode == 2'b10) ? (ram_base | off) : m_addr;
    if (!size_byte) b[0] = 1'b0;
    return b;
  endfunction

  function automatic string mode_tag();
    if (addr_mode == 2'b00) return "R3 post-increment address";
    if (addr_mode == 2'b10) return "R5 peripheral-offset address";
    return "R4 fixed address";
  endfunction

  task automatic configure(input logic b, input logic d, input logic [1:0] m,
                           input logic nw, input logic [AW-1:0] s, input logic [CW-1:0] c);
    @(negedge clk);
    enable = 1'b0; size_byte = b; dir_to_per = d; addr_mode = m; null_wr = nw;
    ram_base = s; xfer_count = c; per_addr_cfg = PW'($urandom);
    @(negedge clk);
    enable = 1'b1;
    m_addr = s;
    m_cnt  = 0;
  endtask

  // Called at a negedge with the channel idle; returns at a negedge, idle.
  task automatic xfer(input logic [AW-1:0] off);
    logic [AW-1:0] ea;
    logic [DW-1:0] src, expd;
    logic          lst;
    req = 1'b1; req_offset = off; per_rdata = DW'($urandom);
    @(negedge clk);
    req = 1'b0; req_offset = AW'($urandom);
    ea = exp_eff(off);
    chk("R7 read strobe on RAM", 32'(ram_rd), 32'(dir_to_per));
    chk("R7 read strobe on peripheral", 32'(per_rd), 32'(!dir_to_per));
    chk(mode_tag(), 32'(ram_addr), 32'(ea));
    chk("R6 peripheral address", 32'(per_addr), 32'(per_addr_cfg));
    if (!size_byte) chk("R1 word address bit 0", 32'(ram_addr[0]), 32'd0);
    src  = dir_to_per ? ram_fn(ea) : per_rdata;
    expd = size_byte ? {8'h00, src[7:0]} : src;
    @(negedge clk);
    chk("R9 write phase address held", 32'(ram_addr), 32'(ea));
    chk("R7 RAM write strobe", 32'(ram_wr), 32'(!dir_to_per));
    chk("R8 peripheral write strobe", 32'(per_wr), 32'(dir_to_per || null_wr));
    if (!dir_to_per)
      chk(size_byte ? "R2 byte data to RAM" : "R1 word data to RAM", 32'(ram_wdata), 32'(expd));
    if (dir_to_per)
      chk(size_byte ? "R2 byte data to peripheral" : "R1 word data to peripheral", 32'(per_wdata), 32'(expd));
    else if (null_wr)
      chk("R8 null write data", 32'(per_wdata), 32'd0);
    m_cnt++;
    lst = (m_cnt == int'(xfer_count));
    if (lst) begin
      m_addr = ram_base;
      m_cnt  = 0;
    end else if (addr_mode == 2'b00) begin
      m_addr = m_addr + (size_byte ? AW'(1) : AW'(2));
    end
    @(negedge clk);
    chk("R10 done pulse", 32'(done), 32'(lst));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] s, o;
    logic [1:0]    m;
    int            n;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; enable = 1'b0; size_byte = 1'b0; dir_to_per = 1'b0; addr_mode = 2'b00;
    null_wr = 1'b0; ram_base = '0; per_addr_cfg = '0; xfer_count = CW'(1); req = 1'b0;
    req_offset = '0; per_rdata = '0; ram_conflict = 1'b0; per_conflict = 1'b0;
    m_addr = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset strobes", 32'({ram_rd, ram_wr, per_rd, per_wr}), 32'd0);
    chk("R12 reset status", 32'({done, col_ram, col_per}), 32'd0);
    rst_n = 1'b1;

    // R12: request while disabled is ignored
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R12 request ignored when disabled", 32'({ram_rd, per_rd}), 32'd0);
    @(negedge clk);
    chk("R12 no write when disabled", 32'({ram_wr, per_wr}), 32'd0);

    // Directed: odd base in word and byte post-increment
    configure(1'b0, 1'b1, 2'b00, 1'b0, AW'(11'h013), CW'(3));
    for (int i = 0; i < 4; i++) xfer('0);
    configure(1'b1, 1'b0, 2'b00, 1'b1, AW'(11'h021), CW'(2));
    for (int i = 0; i < 3; i++) xfer('0);
    // Directed: reserved mode behaves as fixed
    configure(1'b1, 1'b1, 2'b11, 1'b0, AW'(11'h045), CW'(3));
    for (int i = 0; i < 3; i++) xfer(AW'(11'h7));

    // Random setups
    for (int k = 0; k < 60; k++) begin
      m = 2'($urandom);
      n = 1 + ($urandom % 4);
      s = AW'($urandom);
      if (m == 2'b10) s = s & ~AW'(31);
      configure(1'($urandom), 1'($urandom), m, 1'($urandom), s, CW'(n));
      for (int i = 0; i <= n; i++) begin
        o = AW'($urandom) & AW'(31);
        xfer(o);
      end
    end

    // R9: request during read phase held and served with its own offset
    configure(1'b0, 1'b1, 2'b10, 1'b0, AW'(11'h100), CW'(8));
    req = 1'b1; req_offset = AW'(3);
    @(negedge clk);
    req_offset = AW'(5);
    chk("R9 first read phase", 32'(ram_rd), 32'd1);
    chk("R5 first offset", 32'(ram_addr), 32'h102);
    @(negedge clk);
    req = 1'b0;
    chk("R9 first write phase", 32'(per_wr), 32'd1);
    @(negedge clk);
    chk("R9 pending served at once", 32'(ram_rd), 32'd1);
    chk("R9 pending uses its own offset", 32'(ram_addr), 32'h104);
    @(negedge clk);
    chk("R9 pending write phase", 32'(per_wr), 32'd1);
    @(negedge clk);
    chk("R9 no extra transfer", 32'({ram_rd, per_rd, ram_wr, per_wr}), 32'd0);

    // R11: collision flags
    configure(1'b0, 1'b0, 2'b00, 1'b1, AW'(11'h200), CW'(8));
    req = 1'b1;
    @(negedge clk);
    req = 1'b0; per_conflict = 1'b1;
    @(negedge clk);
    per_conflict = 1'b0; ram_conflict = 1'b1;
    @(negedge clk);
    ram_conflict = 1'b0;
    chk("R11 RAM collision set", 32'(col_ram), 32'd1);
    chk("R11 conflict in read phase ignored", 32'(col_per), 32'd0);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    per_conflict = 1'b1;
    @(negedge clk);
    per_conflict = 1'b0;
    chk("R11 peripheral collision set", 32'(col_per), 32'd1);
    chk("R11 RAM collision sticky", 32'(col_ram), 32'd1);
    repeat (2) @(negedge clk);
    chk("R11 flags hold while enabled", 32'({col_ram, col_per}), 32'd3);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 flags cleared by disable", 32'({col_ram, col_per}), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule